// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the reset for a processor from two sources. The first is a digital "supply good" level from an external voltage comparator. While that level is low, reset is held. After it returns, reset stays on for a fixed hold time so that the supply and the processor can settle. The second source is a watchdog on an input pin that the processor toggles in software. If the toggling stops for longer than the active timeout, the block issues one reset pulse of the same hold time and raises a fault flag.

All times are counts of a slow tick-enable strobe, so a tick of 1 kHz maps the defaults to 50 ms of hold, a 100 ms short timeout and a 1.6 s long timeout. A 200 ms hold is obtained by setting the hold count to 200. The timeout can be short, long, or a count given on an input. After every reset the long timeout applies, because software may not be able to service the watchdog right away. The selected timeout takes over only once the first toggle arrives after reset is released.

A disable input turns the watchdog off, for boards that leave the pin unused. Both reset polarities come straight from registers. The watchdog pin is brought into the clock domain through a synchronizer before its edges are detected.

Top module: `cpu_reset_guard`

## Requirements
- R1: In the cycle after `pwr_ok_i` is sampled low, `rst_o` is 1. `rst_n_o` is always the inverse of `rst_o`. A reset caused by the supply alone leaves `wdt_fault_o` at 0.
- R2: Once `pwr_ok_i` is high again with a tick in every cycle, `rst_o` stays 1 for exactly `RST_TICKS` cycles, counted from the cycle in which the supply is first seen good.
- R3: A watchdog timeout sets `rst_o` and `wdt_fault_o` on the same clock edge. The pulse lasts `RST_TICKS` ticks. `wdt_fault_o` clears on the edge at which that reset ends.
- R4: After any reset is released, the watchdog uses `LONG_TICKS` whatever `tmo_sel_i` says. With no input edges, a pulse follows every `LONG_TICKS` ticks of released reset, without end.
- R5: After the first edge on `wdt_in_i` that follows the release, the timeout comes from `tmo_sel_i`: 0 gives `SHORT_TICKS`, 1 and 3 give `LONG_TICKS`, and 2 gives `tmo_adj_i`, where a value of 0 counts as 1. With one tick per cycle, for a timeout L, reset rises L+2 edges after the edge that samples the input change: two synchronizer stages, one edge to clear the counter, then L counting edges.
- R6: Rising and falling edges of `wdt_in_i` both restart the timeout. Toggling faster than the active timeout keeps `rst_o` at 0.
- R7: Edges on `wdt_in_i` that occur while reset is asserted are ignored. The next period still uses the long timeout.
- R8: While `wdt_off_i` is 1, the watchdog never times out.
- R9: The hold timer and the watchdog advance only in cycles with `tick_i` high. Without ticks, reset is never released and never raised by the watchdog.
- R10: A supply loss during a watchdog reset restarts the hold time from zero. `wdt_fault_o` stays 1 until that lengthened reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's own state |
| tick_i | input | 1 | Time-base strobe; all counters advance only on it |
| pwr_ok_i | input | 1 | Supply-good level from the external comparator |
| wdt_in_i | input | 1 | Watchdog toggle pin, asynchronous |
| wdt_off_i | input | 1 | 1 disables the watchdog |
| tmo_sel_i | input | 2 | Timeout select: 0 short, 1 long, 2 adjustable, 3 long |
| tmo_adj_i | input | CNT_W | Adjustable timeout in ticks (0 counts as 1) |
| rst_o | output | 1 | Active-high processor reset |
| rst_n_o | output | 1 | Active-low processor reset |
| wdt_fault_o | output | 1 | Set by a watchdog timeout, cleared when its reset ends |

## Verification
The bench builds the block with `RST_TICKS`=5, `SHORT_TICKS`=6, `LONG_TICKS`=20 and `CNT_W`=8. With those values every hold, short, long and adjustable period fits in a few dozen cycles. Repeated long-timeout pulses, a supply loss in the middle of a watchdog pulse, and the clamp of a zero adjustable count can therefore all be measured cycle by cycle. The tick is held high in most tests, so each period can be checked as an exact cycle count. The tick is held low only in the tests that show nothing advances without it.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    TMO_SHORT = 2'd0,
    TMO_LONG  = 2'd1,
    TMO_ADJ   = 2'd2,
    TMO_LONG2 = 2'd3
  } tmo_sel_e;
endpackage

// File: rtl/rg_kick_sync.sv
module rg_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic kick_edge_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], kick_i};
  end

  assign kick_edge_o = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/rg_hold_timer.sv
module rg_hold_timer #(
  parameter int RST_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pwr_ok_i,
  input  logic wd_expire_i,
  output logic active_o,
  output logic active_n_o,
  output logic release_o
);
  localparam int HW = $clog2(RST_TICKS + 1);
  localparam logic [HW-1:0] LAST = HW'(RST_TICKS - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic act_d;

  assign release_o = active_o && pwr_ok_i && tick_i && (cnt_q == LAST);

  always_comb begin
    act_d = active_o;
    cnt_d = cnt_q;
    if (!pwr_ok_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (active_o) begin
      if (tick_i) begin
        if (cnt_q == LAST) begin
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (wd_expire_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o   <= 1'b1;
      active_n_o <= 1'b0;
      cnt_q      <= '0;
    end else begin
      active_o   <= act_d;
      active_n_o <= ~act_d;
      cnt_q      <= cnt_d;
    end
  end
endmodule

// File: rtl/rg_wdog.sv
module rg_wdog
  import rg_pkg::*;
#(
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 1600,
  parameter int CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             off_i,
  input  logic             kick_edge_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] adj_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] last;

  always_comb begin
    if (long_q) begin
      limit = LONG_C;
    end else begin
      unique case (tmo_sel_e'(sel_i))
        TMO_SHORT: limit = SHORT_C;
        TMO_ADJ:   limit = (adj_i == '0) ? CNT_W'(1) : adj_i;
        default:   limit = LONG_C;
      endcase
    end
    last = limit - CNT_W'(1);
  end

  assign expire_o = !hold_i && !off_i && !kick_edge_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q  <= '0;
      long_q <= 1'b1;
    end else if (kick_edge_i) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (off_i) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      cnt_q  <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cpu_reset_guard.sv
module cpu_reset_guard #(
  parameter int RST_TICKS   = 50,
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 1600,
  parameter int CNT_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             pwr_ok_i,
  input  logic             wdt_in_i,
  input  logic             wdt_off_i,
  input  logic [1:0]       tmo_sel_i,
  input  logic [CNT_W-1:0] tmo_adj_i,
  output logic             rst_o,
  output logic             rst_n_o,
  output logic             wdt_fault_o
);
  logic kick_edge;
  logic expire;
  logic release_p;

  rg_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .kick_i      (wdt_in_i),
    .kick_edge_o (kick_edge)
  );

  rg_wdog #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CNT_W       (CNT_W)
  ) u_wdog (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .hold_i      (rst_o),
    .off_i       (wdt_off_i),
    .kick_edge_i (kick_edge),
    .sel_i       (tmo_sel_i),
    .adj_i       (tmo_adj_i),
    .expire_o    (expire)
  );

  rg_hold_timer #(.RST_TICKS(RST_TICKS)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .pwr_ok_i    (pwr_ok_i),
    .wd_expire_i (expire),
    .active_o    (rst_o),
    .active_n_o  (rst_n_o),
    .release_o   (release_p)
  );

  // Fault: set by a timeout, cleared when the reset it caused (possibly extended) ends
  always_ff @(posedge clk) begin
    if (rst)            wdt_fault_o <= 1'b0;
    else if (expire)    wdt_fault_o <= 1'b1;
    else if (release_p) wdt_fault_o <= 1'b0;
  end
endmodule

// File: rtl/rg_guard_chk.sv
module rg_guard_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic pwr_ok_i,
  input logic wdt_off_i,
  input logic rst_o,
  input logic rst_n_o,
  input logic wdt_fault_o
);
  p_polarity_r1: assert property (@(posedge clk) disable iff (rst)
    rst_n_o == !rst_o);

  p_supply_low_r1: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok_i |=> rst_o);

  p_release_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> ($past(tick_i) && $past(pwr_ok_i)));

  p_fault_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_fault_o) |-> $rose(rst_o));

  p_fault_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_fault_o) |-> $fell(rst_o));

  p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    (wdt_off_i && pwr_ok_i && !rst_o) |=> !rst_o);

  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rst_o && !tick_i) |=> rst_o);
endmodule

bind cpu_reset_guard rg_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .pwr_ok_i    (pwr_ok_i),
  .wdt_off_i   (wdt_off_i),
  .rst_o       (rst_o),
  .rst_n_o     (rst_n_o),
  .wdt_fault_o (wdt_fault_o)
);

// File: tb/cpu_reset_guard_test.sv
module cpu_reset_guard_test;
  localparam int RSTT  = 5;
  localparam int SHORT = 6;
  localparam int LONG  = 20;
  localparam int CW    = 8;

  // table: select, adjust value, expected low samples after a single kick (L+3)
  localparam int NV = 5;
  localparam int TAB_SEL [NV] = '{0, 1, 2, 2, 3};
  localparam int TAB_ADJ [NV] = '{0, 0, 9, 0, 0};
  localparam int TAB_EXP [NV] = '{SHORT + 3, LONG + 3, 12, 4, LONG + 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic pwr_ok = 1'b1;
  logic kick = 1'b0;
  logic wd_off = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [CW-1:0] adj = '0;
  logic rst_o, rst_n_o, fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cpu_reset_guard #(
    .RST_TICKS(RSTT), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .tick_i(tick), .pwr_ok_i(pwr_ok), .wdt_in_i(kick),
    .wdt_off_i(wd_off), .tmo_sel_i(sel), .tmo_adj_i(adj),
    .rst_o(rst_o), .rst_n_o(rst_n_o), .wdt_fault_o(fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count samples (current one included) while reset is high
  task automatic meas_high(output int n);
    n = 0;
    while (rst_o === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic meas_low(output int n);
    n = 0;
    while (rst_o === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic supply_cycle(input string tag);
    int n;
    pwr_ok = 1'b0;
    @(negedge clk);
    check({tag, " R1 reset on supply loss"}, int'(rst_o), 1);
    pwr_ok = 1'b1;
    meas_high(n);
    check({tag, " R2 hold length"}, n, RSTT);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    repeat (4) @(negedge clk);
    check("R1 reset state rst_o", int'(rst_o), 1);
    check("R1 reset state rst_n_o", int'(rst_n_o), 0);
    check("R3 reset state fault", int'(fault), 0);
    rst = 1'b0;
    meas_high(n);
    check("R2 power-up hold", n, RSTT);

    // R4: long timeout after reset even with short selected, repeating
    meas_low(n);
    check("R4 first period long", n, LONG);
    check("R3 fault set with pulse", int'(fault), 1);
    check("R1 complement during pulse", int'(rst_n_o), 0);
    meas_high(n);
    check("R3 pulse length", n, RSTT);
    check("R3 fault cleared at end", int'(fault), 0);
    meas_low(n);
    check("R4 repeated long period", n, LONG);
    meas_high(n);
    check("R3 second pulse length", n, RSTT);

    // R5: table of timeout selections after one kick
    for (int i = 0; i < NV; i++) begin
      sel = 2'(TAB_SEL[i]);
      adj = CW'(TAB_ADJ[i]);
      supply_cycle("R5 table");
      kick = ~kick;
      meas_low(n);
      check($sformatf("R5 vector %0d timeout", i), n, TAB_EXP[i]);
      meas_high(n);
      check($sformatf("R5 vector %0d pulse", i), n, RSTT);
    end

    // R6: both edge polarities keep the watchdog alive in short mode
    sel = 2'd0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      kick = ~kick;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (rst_o) seen++;
      end
    end
    check("R6 keep-alive no reset", seen, 0);

    // R8: disabled watchdog never fires
    wd_off = 1'b1;
    seen = 0;
    for (int c = 0; c < 3 * LONG; c++) begin
      @(negedge clk);
      if (rst_o || fault) seen++;
    end
    check("R8 disabled no reset", seen, 0);

    // R7: kicks during reset are ignored
    wd_off = 1'b0;
    pwr_ok = 1'b0;
    @(negedge clk);
    check("R1 supply loss reset", int'(rst_o), 1);
    check("R1 supply loss no fault", int'(fault), 0);
    for (int k = 0; k < 3; k++) begin
      kick = ~kick;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    pwr_ok = 1'b1;
    meas_high(n);
    check("R7 hold after loss", n, RSTT);
    meas_low(n);
    check("R7 still long after kicks in reset", n, LONG);

    // R10: supply loss during watchdog pulse restarts hold
    check("R10 fault at pulse start", int'(fault), 1);
    repeat (2) @(negedge clk);
    pwr_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 fault kept during loss", int'(fault), 1);
    pwr_ok = 1'b1;
    meas_high(n);
    check("R10 restarted hold", n, RSTT);
    check("R10 fault cleared", int'(fault), 0);

    // R9: watchdog does not advance without ticks
    tick = 1'b0;
    seen = 0;
    for (int c = 0; c < 2 * LONG; c++) begin
      @(negedge clk);
      if (rst_o) seen++;
    end
    check("R9 no tick no timeout", seen, 0);
    tick = 1'b1;
    meas_low(n);
    check("R9 timeout counts ticks only", n, LONG);
    meas_high(n);

    // R9: hold does not release without ticks
    tick = 1'b0;
    pwr_ok = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 no tick stays in reset", int'(rst_o), 1);
    tick = 1'b1;
    meas_high(n);
    check("R9 hold counts ticks only", n, RSTT);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule